// File: doc/BRIEF.md
# Configuration Register Space for a Display-Class Target

This block holds the 256-byte configuration space of a simple display-class target on a peripheral bus. Accesses carry a byte address and a byte count of 1, 2 or 4. Reads are combinational and return the addressed bytes packed little-endian into a 32-bit word. Writes land on the next rising clock edge and are filtered byte by byte. Some bytes are locked, one nibble is preserved, the first base register depends on a framebuffer option, a window of header addresses is discarded, and the expansion-ROM register is masked.

The surrounding bus logic drives the access fields. Memory decode logic uses the outputs: the decoded base of the first memory window, the expansion-ROM base and its enable bit, and two one-cycle strobes that report an update of either base. An asynchronous active-low reset rebuilds the whole space. A synchronous reload input restores only the command and status defaults.

Top module: `cfgspace_regfile`

## Requirements
- R1: After `rst_n` is low, every byte reads 0x00 except these: bytes 0x00–0x01 read 0x1234 and bytes 0x02–0x03 read 0x1111 (little-endian); byte 0x0B reads 0x03; bytes 0x04 and 0x07 read 0x03 and 0x02; bytes 0x10–0x13 read 0x00000008 when `fb_en` is high during reset.
- R2: A one-cycle `cmd_reload` pulse sets bytes 0x04..0x07 back to 0x03, 0x00, 0x00, 0x02. It touches no other byte and takes priority over a write in the same cycle.
- R3: A read returns byte `addr+i` in `rdata[8i+7:8i]` for i below `len`. Byte lanes at or above `len`, and lanes whose address would pass 0xFF, read zero.
- R4: Bytes 0x04 and 0x06 never change on a write. The other bytes covered by the same access are still written.
- R5: A write whose start address is in 0x14..0x2F is discarded completely, including any bytes it covers at 0x30 or above.
- R6: A write that starts at 0x30 is ANDed with 0xFFFFFC01 over all 32 bits before it is applied. `rom_en` is bit 0 of byte 0x30. `rom_base` is bytes 0x30..0x33 with bits 9:0 cleared.
- R7: `rom_chg` is high for exactly the one cycle after a write that starts at 0x30, whether or not the value changed.
- R8: A write to byte 0x10 keeps that byte's low four bits. `bar0_base` is bytes 0x10..0x13 with bits 3:0 cleared.
- R9: Bytes 0x10..0x13 accept writes only while `fb_en` is high. `bar0_chg` is high for the one cycle after a write only if at least one of those bytes changed value.
- R10: A write whose span would pass 0xFF writes only the bytes up to 0xFF.
- R11: All other bytes, such as the interrupt-line byte 0x3C, store and return written data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low full initialisation |
| cmd_reload | input | 1 | Restore command and status defaults |
| fb_en | input | 1 | Linear-framebuffer option; enables the first base register |
| wr_en | input | 1 | Write strobe for the current access |
| addr | input | 8 | Start byte address |
| len | input | 3 | Byte count: 1, 2 or 4 |
| wdata | input | 32 | Write data, little-endian |
| rdata | output | 32 | Read data, little-endian, combinational |
| bar0_base | output | 32 | Decoded base of the first memory window |
| rom_base | output | 32 | Decoded expansion-ROM base |
| rom_en | output | 1 | Expansion-ROM decode enable |
| bar0_chg | output | 1 | One-cycle pulse after a change of the first base |
| rom_chg | output | 1 | One-cycle pulse after a ROM-register write |

## Verification
The assertions check the following on every cycle:
- each strobe matches the write that preceded it;
- `rom_en` never changes without a ROM strobe;
- the first base stays frozen while the framebuffer option is off;
- byte 0x04 always reads 0x03;
- a read that starts at 0xFF carries no data above its first lane.

Only the directed scenarios can show the actual data values. These include the nibble merge at 0x10, the 32-bit ROM mask applied to a one-byte write, discarding of the header window, truncation at the end of the space, and the reset and reload contents.

// File: rtl/cfgspace_regfile.sv
module cfgspace_regfile #(
  parameter logic [15:0] VENDOR_ID  = 16'h1234,
  parameter logic [15:0] DEVICE_ID  = 16'h1111,
  parameter logic [7:0]  SUB_CLASS  = 8'h00,
  parameter logic [7:0]  BASE_CLASS = 8'h03,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter int          SPACE      = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_reload,
  input  logic        fb_en,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [2:0]  len,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [31:0] bar0_base,
  output logic [31:0] rom_base,
  output logic        rom_en,
  output logic        bar0_chg,
  output logic        rom_chg
);
  localparam int NB = 4;
  localparam logic [7:0] CMD_LO  = 8'h04;
  localparam logic [7:0] CMD_HI  = 8'h05;
  localparam logic [7:0] STS_LO  = 8'h06;
  localparam logic [7:0] STS_HI  = 8'h07;
  localparam logic [7:0] BAR0_A  = 8'h10;
  localparam logic [7:0] HOLE_LO = 8'h14;
  localparam logic [7:0] ROM_A   = 8'h30;
  localparam logic [31:0] ROM_MASK = 32'hFFFF_FC01;

  logic [7:0] cfg [SPACE];

  logic        drop_win, at_rom;
  logic [31:0] wval;
  logic [8:0]  ba  [NB];
  logic [7:0]  ix  [NB];
  logic [7:0]  nb  [NB];
  logic [NB-1:0] we, bar_diff;

  assign drop_win = (addr >= HOLE_LO) && (addr < ROM_A);
  assign at_rom   = (addr == ROM_A);
  assign wval     = at_rom ? (wdata & ROM_MASK) : wdata;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NB; i++) begin
      ba[i]       = {1'b0, addr} + 9'(i);
      ix[i]       = ba[i][7:0];
      nb[i]       = wval[8*i +: 8];
      we[i]       = 1'b0;
      bar_diff[i] = 1'b0;
      if (i < int'(len) && !ba[i][8]) begin
        rdata[8*i +: 8] = cfg[ix[i]];
        if (wr_en && !drop_win) begin
          if (ix[i] == CMD_LO || ix[i] == STS_LO) begin
            we[i] = 1'b0;
          end else if (ix[i][7:2] == BAR0_A[7:2]) begin
            if (fb_en) begin
              if (ix[i] == BAR0_A) nb[i] = {wval[8*i+4 +: 4], cfg[ix[i]][3:0]};
              we[i]       = 1'b1;
              bar_diff[i] = (nb[i] != cfg[ix[i]]);
            end
          end else begin
            we[i] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SPACE; k++) cfg[k] <= 8'h00;
      cfg[8'h00] <= VENDOR_ID[7:0];
      cfg[8'h01] <= VENDOR_ID[15:8];
      cfg[8'h02] <= DEVICE_ID[7:0];
      cfg[8'h03] <= DEVICE_ID[15:8];
      cfg[8'h0A] <= SUB_CLASS;
      cfg[8'h0B] <= BASE_CLASS;
      cfg[8'h0E] <= HDR_TYPE;
      cfg[BAR0_A] <= fb_en ? 8'h08 : 8'h00;
      cfg[CMD_LO] <= 8'h03;
      cfg[CMD_HI] <= 8'h00;
      cfg[STS_LO] <= 8'h00;
      cfg[STS_HI] <= 8'h02;
      bar0_chg <= 1'b0;
      rom_chg  <= 1'b0;
    end else begin
      for (int i = 0; i < NB; i++)
        if (we[i]) cfg[ix[i]] <= nb[i];
      if (cmd_reload) begin
        cfg[CMD_LO] <= 8'h03;
        cfg[CMD_HI] <= 8'h00;
        cfg[STS_LO] <= 8'h00;
        cfg[STS_HI] <= 8'h02;
      end
      bar0_chg <= |bar_diff;
      rom_chg  <= wr_en && at_rom;
    end
  end

  assign bar0_base = {cfg[8'h13], cfg[8'h12], cfg[8'h11], cfg[8'h10][7:4], 4'h0};
  assign rom_base  = {cfg[8'h33], cfg[8'h32], cfg[8'h31][7:2], 10'h000};
  assign rom_en    = cfg[ROM_A][0];
endmodule

// File: rtl/cfgspace_regfile_chk.sv
module cfgspace_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fb_en,
  input logic        wr_en,
  input logic [7:0]  addr,
  input logic [2:0]  len,
  input logic [31:0] rdata,
  input logic [31:0] bar0_base,
  input logic        rom_en,
  input logic        bar0_chg,
  input logic        rom_chg
);
  a_r7_rom_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rom_chg |-> $past(wr_en && addr == 8'h30));

  a_r7_rom_en_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_en != $past(rom_en)) |-> rom_chg);

  a_r9_bar_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bar0_chg |-> ($past(fb_en && wr_en) && bar0_base != $past(bar0_base)));

  a_r9_bar_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fb_en) |-> bar0_base == $past(bar0_base));

  a_r4_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h04 && len == 3'd1) |-> rdata == 32'h0000_0003);

  a_r3_end_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'hFF && len == 3'd4) |-> rdata[31:8] == 24'h0);
endmodule

bind cfgspace_regfile cfgspace_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fb_en(fb_en), .wr_en(wr_en), .addr(addr),
  .len(len), .rdata(rdata), .bar0_base(bar0_base), .rom_en(rom_en),
  .bar0_chg(bar0_chg), .rom_chg(rom_chg));

// File: tb/cfgspace_regfile_test.sv
`timescale 1ns/1ps
module cfgspace_regfile_test;
  logic clk = 0, rst_n = 0, cmd_reload = 0, fb_en = 1, wr_en = 0;
  logic [7:0] addr = 0;
  logic [2:0] len = 1;
  logic [31:0] wdata = 0, rdata, bar0_base, rom_base;
  logic rom_en, bar0_chg, rom_chg;
  int tests = 0, fails = 0;
  logic s_bar, s_rom, n_bar, n_rom;

  always #2.5 clk = ~clk;

  cfgspace_regfile uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic fb);
    @(negedge clk);
    rst_n = 0; fb_en = fb; wr_en = 0; cmd_reload = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] l, output logic [31:0] d);
    @(negedge clk);
    addr = a; len = l; #1;
    d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] l, input logic [31:0] d);
    @(negedge clk);
    addr = a; len = l; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    s_bar = bar0_chg; s_rom = rom_chg;
    @(negedge clk);
    n_bar = bar0_chg; n_rom = rom_chg;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset(1'b1);
    rd(8'h00, 3'd4, d); chk("R1 ids", d, 32'h1111_1234);
    rd(8'h08, 3'd4, d); chk("R1 class", d, 32'h0300_0000);
    rd(8'h0C, 3'd4, d); chk("R1 header", d, 32'h0);
    rd(8'h04, 3'd4, d); chk("R1 cmd/status", d, 32'h0200_0003);
    rd(8'h10, 3'd4, d); chk("R1 bar0 fb", d, 32'h0000_0008);
    rd(8'h30, 3'd4, d); chk("R1 rom", d, 32'h0);
    chk("R1 strobes", {30'h0, bar0_chg, rom_chg}, 32'h0);
  endtask

  task automatic t_reads();
    logic [31:0] d;
    rd(8'h00, 3'd1, d); chk("R3 len1", d, 32'h34);
    rd(8'h01, 3'd2, d); chk("R3 len2", d, 32'h1112);
    rd(8'hFF, 3'd2, d); chk("R3 past end", d, 32'h0);
  endtask

  task automatic t_locked_cmd();
    logic [31:0] d;
    wr(8'h04, 3'd4, 32'hFFFF_FFFF);
    rd(8'h04, 3'd4, d); chk("R4 locked bytes", d, 32'hFF00_FF03);
    @(negedge clk); cmd_reload = 1;
    @(negedge clk); cmd_reload = 0;
    rd(8'h04, 3'd4, d); chk("R2 reload", d, 32'h0200_0003);
    rd(8'h00, 3'd4, d); chk("R2 ids untouched", d, 32'h1111_1234);
    @(negedge clk);
    addr = 8'h05; len = 3'd1; wdata = 32'h55; wr_en = 1; cmd_reload = 1;
    @(negedge clk); wr_en = 0; cmd_reload = 0;
    rd(8'h04, 3'd4, d); chk("R2 reload wins", d, 32'h0200_0003);
  endtask

  task automatic t_bar0();
    logic [31:0] d;
    wr(8'h10, 3'd4, 32'hABCD_EF5F);
    rd(8'h10, 3'd4, d); chk("R8 nibble kept", d, 32'hABCD_EF58);
    chk("R8 bar0_base", bar0_base, 32'hABCD_EF50);
    chk("R9 change pulse", {30'h0, s_bar, n_bar}, 32'h2);
    wr(8'h10, 3'd4, 32'hABCD_EF50);
    chk("R9 no change no pulse", {30'h0, s_bar, n_bar}, 32'h0);
  endtask

  task automatic t_hole();
    logic [31:0] d;
    wr(8'h14, 3'd4, 32'hDEAD_BEEF);
    rd(8'h14, 3'd4, d); chk("R5 dropped", d, 32'h0);
    wr(8'h2E, 3'd4, 32'h1234_5678);
    rd(8'h2C, 3'd4, d); chk("R5 dropped low", d, 32'h0);
    rd(8'h30, 3'd4, d); chk("R5 dropped into rom", d, 32'h0);
    chk("R5 no rom pulse", {31'h0, s_rom}, 32'h0);
  endtask

  task automatic t_rom();
    logic [31:0] d;
    wr(8'h30, 3'd4, 32'hFFFF_FFFF);
    rd(8'h30, 3'd4, d); chk("R6 masked", d, 32'hFFFF_FC01);
    chk("R6 rom_base", rom_base, 32'hFFFF_FC00);
    chk("R6 rom_en", {31'h0, rom_en}, 32'h1);
    chk("R7 pulse", {30'h0, s_rom, n_rom}, 32'h2);
    wr(8'h30, 3'd4, 32'hFFFF_FC01);
    chk("R7 pulse same value", {30'h0, s_rom, n_rom}, 32'h2);
    wr(8'h30, 3'd1, 32'h0000_00FE);
    rd(8'h30, 3'd4, d); chk("R6 byte write", d, 32'hFFFF_FC00);
    chk("R6 rom_en off", {31'h0, rom_en}, 32'h0);
  endtask

  task automatic t_trunc_ram();
    logic [31:0] d;
    wr(8'hFE, 3'd4, 32'hAABB_CCDD);
    rd(8'hFE, 3'd4, d); chk("R10 truncated", d, 32'h0000_CCDD);
    rd(8'h00, 3'd4, d); chk("R10 no wrap", d, 32'h1111_1234);
    wr(8'h3C, 3'd2, 32'h0000_010B);
    rd(8'h3C, 3'd1, d); chk("R11 ram byte", d, 32'h0B);
    rd(8'h3C, 3'd2, d); chk("R11 ram half", d, 32'h010B);
  endtask

  task automatic t_no_fb();
    logic [31:0] d;
    do_reset(1'b0);
    rd(8'h10, 3'd4, d); chk("R1 bar0 no fb", d, 32'h0);
    wr(8'h10, 3'd4, 32'hFFFF_FFFF);
    rd(8'h10, 3'd4, d); chk("R9 bar0 locked", d, 32'h0);
    chk("R9 no pulse", {30'h0, s_bar, n_bar}, 32'h0);
    wr(8'h0F, 3'd4, 32'h1122_3344);
    rd(8'h0C, 3'd4, d); chk("R9 neighbour written", d, 32'h4400_0000);
    chk("R9 bar0_base", bar0_base, 32'h0);
  endtask

  initial begin
    t_reset_state();
    t_reads();
    t_locked_cmd();
    t_bar0();
    t_hole();
    t_rom();
    t_trunc_ram();
    t_no_fb();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule